// File: doc/BRIEF.md
# Dirty Block Eviction Queue

This block sits between a write-back data cache and the next level of the memory hierarchy. Whenever the cache replaces a block whose dirty bit is set, it offers the whole block (eight 64-bit words) and its block address to the queue. The queue holds up to eight such blocks. A full flag tells the cache to stall its eviction, and an empty flag tells it that nothing is waiting.

The drain side works by itself, at the same time as the cache keeps serving other requests. It takes the oldest stored block and sends it as one address phase followed by eight data beats of 64 bits each. Each phase and each beat uses a valid/ready handshake. A slot is released only when the last beat of its block has been accepted. Blocks offered with the dirty bit clear are not stored.

Top module: `victim_wbuf`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty` is 1, `full` is 0, and neither `mem_addr_valid` nor `mem_data_valid` is asserted.
- R2: An offer with `push_valid`=1 and `push_dirty`=0 is not stored. After such offers into an idle queue, `empty` stays 1 and no address phase appears.
- R3: `full` is 1 exactly when eight blocks are held. A dirty offer made while `full` is 1 is dropped, and that block never appears on the drain side.
- R4: Blocks leave in the order in which they were accepted. Each address phase carries the block address of the oldest held block on `mem_addr`.
- R5: Each held block produces exactly one address phase and then eight data beats. Valid is never asserted for both phases together. Beat k (k = 0..7) carries bits [64k+63:64k] of the pushed block, and `mem_data_last` is 1 only on beat 7.
- R6: While a valid is asserted and its ready is low, the valid stays asserted and `mem_addr`, `mem_data` and `mem_data_last` do not change.
- R7: A slot is freed only in the cycle in which the final beat is accepted. An accepted push and such a completion in the same cycle leave the occupancy unchanged. When the queue is empty, no valid is asserted.
- R8: `empty` is 1 exactly when no block is held, and `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Cache offers an evicted block this cycle |
| push_dirty | input | 1 | The offered block was modified |
| push_addr | input | ADDR_W | Block address of the offered block |
| push_data | input | BEATS*BEAT_W | Whole block contents, beat 0 in the low bits |
| full | output | 1 | All slots are held, so the cache must stall its eviction |
| empty | output | 1 | No slot is held |
| mem_addr_valid | output | 1 | Address phase offered to the next level |
| mem_addr_ready | input | 1 | Next level takes the address phase |
| mem_addr | output | ADDR_W | Block address being written back |
| mem_data_valid | output | 1 | Data beat offered to the next level |
| mem_data_ready | input | 1 | Next level takes the data beat |
| mem_data | output | BEAT_W | Current 64-bit beat |
| mem_data_last | output | 1 | Current beat is the final one of its block |

## Verification
The case of interest is a new dirty eviction accepted in the same cycle as the final beat of the oldest block is taken. The occupancy must then stay as it was, and the slot being written must not overlap the slot being freed. The bench provokes this with long pseudo-random stretches that alternate sparse and dense pushing against ready lines that are often low, so the coincidence happens at many fill levels, including one held block. A cycle-accurate queue model judges it. The model predicts `full`, `empty`, the address and every beat in each cycle, and it counts how often the coincidence occurred so that a run in which it never happened is reported.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
   // drain side phase of the block currently at the head
   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } vwb_phase_e;
endpackage

// File: rtl/vwb_ptrs.sv
module vwb_ptrs #(
   parameter int  DEPTH     = 8,
   parameter bit  REG_FLAGS = 1'b1,
   localparam int PTR_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic             pop_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic             full,
   output logic             empty
);
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (push_en && !pop_en) cnt_d = cnt_q + CNT_W'(1);
      else if (pop_en && !push_en) cnt_d = cnt_q - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wr_idx <= '0;
         rd_idx <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (push_en) wr_idx <= wr_idx + PTR_W'(1);
         if (pop_en)  rd_idx <= rd_idx + PTR_W'(1);
      end
   end

   generate
      if (REG_FLAGS) begin : g_reg_flags
         logic full_q, empty_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q  <= 1'b0;
               empty_q <= 1'b1;
            end else begin
               full_q  <= (cnt_d == CNT_W'(DEPTH));
               empty_q <= (cnt_d == '0);
            end
         end
         assign full  = full_q;
         assign empty = empty_q;
      end else begin : g_cmp_flags
         assign full  = (cnt_q == CNT_W'(DEPTH));
         assign empty = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/vwb_store.sv
module vwb_store #(
   parameter int  DEPTH  = 8,
   parameter int  ADDR_W = 28,
   parameter int  BEAT_W = 64,
   parameter int  BEATS  = 8,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int BIDX_W = $clog2(BEATS),
   localparam int BLK_W  = BEATS * BEAT_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic [PTR_W-1:0]  rd_idx,
   input  logic [BIDX_W-1:0] rd_beat,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BEAT_W-1:0] rd_data
);
   logic [ADDR_W-1:0] addr_mem [DEPTH];
   logic [BLK_W-1:0]  blk_mem  [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(e))) begin
               addr_mem[e] <= wr_addr;
               blk_mem[e]  <= wr_blk;
            end
         end
      end
   endgenerate

   logic [BLK_W-1:0] head_blk;
   assign head_blk = blk_mem[rd_idx];
   assign rd_addr  = addr_mem[rd_idx];

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < BEATS; k++) begin
         if (rd_beat == BIDX_W'(k)) rd_data = head_blk[k*BEAT_W +: BEAT_W];
      end
   end
endmodule

// File: rtl/vwb_drain.sv
module vwb_drain
   import vwb_pkg::*;
#(
   parameter int  BEATS  = 8,
   localparam int BIDX_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have_entry,
   input  logic              addr_ready,
   input  logic              data_ready,
   output logic              addr_valid,
   output logic              data_valid,
   output logic              data_last,
   output logic [BIDX_W-1:0] beat_idx,
   output logic              pop
);
   vwb_phase_e phase_q;
   logic [BIDX_W-1:0] beat_q;

   assign addr_valid = (phase_q == PH_ADDR) && have_entry;
   assign data_valid = (phase_q == PH_DATA);
   assign data_last  = data_valid && (beat_q == BIDX_W'(BEATS - 1));
   assign pop        = data_valid && data_ready && data_last;
   assign beat_idx   = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_ADDR;
         beat_q  <= '0;
      end else begin
         case (phase_q)
            PH_ADDR: begin
               if (addr_valid && addr_ready) begin
                  phase_q <= PH_DATA;
                  beat_q  <= '0;
               end
            end
            default: begin
               if (data_ready) begin
                  if (data_last) begin
                     phase_q <= PH_ADDR;
                     beat_q  <= '0;
                  end else begin
                     beat_q <= beat_q + BIDX_W'(1);
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/victim_wbuf.sv
module victim_wbuf #(
   parameter int  DEPTH     = 8,
   parameter int  ADDR_W    = 28,
   parameter int  BEAT_W    = 64,
   parameter int  BEATS     = 8,
   parameter bit  REG_FLAGS = 1'b1,
   localparam int PTR_W     = $clog2(DEPTH),
   localparam int BIDX_W    = $clog2(BEATS),
   localparam int BLK_W     = BEATS * BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic              push_dirty,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [BLK_W-1:0]  push_data,
   output logic              full,
   output logic              empty,
   output logic              mem_addr_valid,
   input  logic              mem_addr_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_data_valid,
   input  logic              mem_data_ready,
   output logic [BEAT_W-1:0] mem_data,
   output logic              mem_data_last
);
   // elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("victim_wbuf: DEPTH must be a power of two, at least 2");
      end
      if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
         $error("victim_wbuf: BEATS must be a power of two, at least 2");
      end
      if (ADDR_W < 1 || BEAT_W < 8) begin : g_bad_width
         $error("victim_wbuf: ADDR_W or BEAT_W too small");
      end
   endgenerate

   logic              push_en;
   logic              pop;
   logic [PTR_W-1:0]  wr_idx, rd_idx;
   logic [BIDX_W-1:0] beat_idx;

   assign push_en = push_valid && push_dirty && !full;

   vwb_ptrs #(
      .DEPTH     (DEPTH),
      .REG_FLAGS (REG_FLAGS)
   ) u_ptrs (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_en (push_en),
      .pop_en  (pop),
      .wr_idx  (wr_idx),
      .rd_idx  (rd_idx),
      .full    (full),
      .empty   (empty)
   );

   vwb_store #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .BEAT_W (BEAT_W),
      .BEATS  (BEATS)
   ) u_store (
      .clk     (clk),
      .wr_en   (push_en),
      .wr_idx  (wr_idx),
      .wr_addr (push_addr),
      .wr_blk  (push_data),
      .rd_idx  (rd_idx),
      .rd_beat (beat_idx),
      .rd_addr (mem_addr),
      .rd_data (mem_data)
   );

   vwb_drain #(
      .BEATS (BEATS)
   ) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .have_entry (!empty),
      .addr_ready (mem_addr_ready),
      .data_ready (mem_data_ready),
      .addr_valid (mem_addr_valid),
      .data_valid (mem_data_valid),
      .data_last  (mem_data_last),
      .beat_idx   (beat_idx),
      .pop        (pop)
   );
endmodule

// File: rtl/vwb_checker.sv
module vwb_checker #(
   parameter int  DEPTH  = 8,
   parameter int  ADDR_W = 28,
   parameter int  BEAT_W = 64,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic              push_dirty,
   input logic              full,
   input logic              empty,
   input logic              mem_addr_valid,
   input logic              mem_addr_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_data_valid,
   input logic              mem_data_ready,
   input logic [BEAT_W-1:0] mem_data,
   input logic              mem_data_last
);
   logic taken, done;
   logic [CNT_W-1:0] occ_q;

   assign taken = push_valid && push_dirty && !full;
   assign done  = mem_data_valid && mem_data_ready && mem_data_last;

   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else if (taken && !done) occ_q <= occ_q + CNT_W'(1);
      else if (done && !taken) occ_q <= occ_q - CNT_W'(1);
   end

   // R3: full tracks the occupancy seen at the ports
   p_full_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full == (occ_q == CNT_W'(DEPTH)));

   // R8: empty tracks the occupancy seen at the ports
   p_empty_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (occ_q == '0));

   // R8: flags exclusive
   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R2: clean offer into an idle queue leaves it idle
   p_clean_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && push_valid && !push_dirty) |=> empty);

   // R5: address and data phases never overlap
   p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_addr_valid && mem_data_valid));

   // R6: address phase held under backpressure
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr_valid && !mem_addr_ready) |=> (mem_addr_valid && $stable(mem_addr)));

   // R6: data beat held under backpressure
   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_data_valid && !mem_data_ready) |=>
         (mem_data_valid && $stable(mem_data) && $stable(mem_data_last)));

   // R7: nothing offered downstream while empty
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!mem_addr_valid && !mem_data_valid));

   // R7: simultaneous accept and completion keep the flags
   p_swap_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && done) |=> ($stable(full) && $stable(empty)));
endmodule

bind victim_wbuf vwb_checker #(
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .BEAT_W (BEAT_W)
) u_vwb_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .push_valid     (push_valid),
   .push_dirty     (push_dirty),
   .full           (full),
   .empty          (empty),
   .mem_addr_valid (mem_addr_valid),
   .mem_addr_ready (mem_addr_ready),
   .mem_addr       (mem_addr),
   .mem_data_valid (mem_data_valid),
   .mem_data_ready (mem_data_ready),
   .mem_data       (mem_data),
   .mem_data_last  (mem_data_last)
);

// File: tb/victim_wbuf_bench.sv
`timescale 1ns/1ps
module victim_wbuf_bench;
   localparam int DEPTH  = 8;
   localparam int ADDR_W = 28;
   localparam int BEAT_W = 64;
   localparam int BEATS  = 8;
   localparam int BLK_W  = BEATS * BEAT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              push_valid = 1'b0, push_dirty = 1'b0;
   logic [ADDR_W-1:0] push_addr = '0;
   logic [BLK_W-1:0]  push_data = '0;
   logic              full, empty;
   logic              mem_addr_valid, mem_data_valid, mem_data_last;
   logic              mem_addr_ready = 1'b0, mem_data_ready = 1'b0;
   logic [ADDR_W-1:0] mem_addr;
   logic [BEAT_W-1:0] mem_data;

   always #2.5 clk = ~clk;

   victim_wbuf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_victim_wbuf (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_dirty(push_dirty),
      .push_addr(push_addr), .push_data(push_data), .full(full), .empty(empty),
      .mem_addr_valid(mem_addr_valid), .mem_addr_ready(mem_addr_ready), .mem_addr(mem_addr),
      .mem_data_valid(mem_data_valid), .mem_data_ready(mem_data_ready),
      .mem_data(mem_data), .mem_data_last(mem_data_last));

   int total = 0, bad = 0, coin = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] addr_of(input int id);
      return ADDR_W'(id * 37 + 11);
   endfunction

   function automatic logic [BEAT_W-1:0] beat_of(input int id, input int k);
      return {32'(id) ^ 32'h5A5A_0000, 32'(k) ^ 32'(id << 4)};
   endfunction

   // bench queue model
   int q [64];
   int qh = 0, qt = 0, mcnt = 0, mb = 0;
   bit mph = 1'b0;

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      int id = 1;
      bit prev_stall = 1'b0;
      logic [63:0] prev_pay = '0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(empty === 1'b1, "R1", "empty in reset", 64'(empty), 64'd1);
      chk(full === 1'b0, "R1", "full in reset", 64'(full), 64'd0);
      chk(!mem_addr_valid && !mem_data_valid, "R1", "valid in reset",
          64'({mem_addr_valid, mem_data_valid}), 64'd0);
      rst_n = 1'b1;

      for (int c = 0; c < 3000; c++) begin
         bit pv, pd, ar, dr, acc, popd;
         logic [63:0] pay;
         string te;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (c < 4) begin                // clean offers only
            pv = 1'b1; pd = 1'b0; ar = 1'b0; dr = 1'b0;
         end else if (c < 16) begin      // overfill
            pv = 1'b1; pd = 1'b1; ar = 1'b0; dr = 1'b0;
         end else if (c < 26) begin      // hold under backpressure
            pv = 1'b0; pd = 1'b0; ar = 1'b0; dr = 1'b0;
         end else if (c < 2700) begin    // mixed traffic
            pv = ((c / 150) % 2 == 0) ? (lfsr[2:0] == 3'd0) : (lfsr[0] | lfsr[1]);
            pd = lfsr[7] | lfsr[8];
            ar = lfsr[5] | lfsr[6];
            dr = lfsr[9] | lfsr[11];
         end else begin                  // drain out
            pv = 1'b0; pd = 1'b0; ar = 1'b1; dr = 1'b1;
         end
         push_valid = pv; push_dirty = pd;
         push_addr  = addr_of(id);
         for (int k = 0; k < BEATS; k++) push_data[k*BEAT_W +: BEAT_W] = beat_of(id, k);
         mem_addr_ready = ar; mem_data_ready = dr;

         te = (c < 6) ? "R2" : "R8";
         chk(full === (mcnt == DEPTH), "R3", "full flag", 64'(full), 64'(mcnt == DEPTH));
         chk(empty === (mcnt == 0), te, "empty flag", 64'(empty), 64'(mcnt == 0));
         if (mcnt == 0) begin
            chk(!mem_addr_valid && !mem_data_valid, "R7", "valid while empty",
                64'({mem_addr_valid, mem_data_valid}), 64'd0);
            pay = '0;
         end else if (!mph) begin
            chk(mem_addr_valid === 1'b1 && mem_data_valid === 1'b0, "R5", "address phase",
                64'({mem_addr_valid, mem_data_valid}), 64'd2);
            chk(mem_addr === addr_of(q[qh]), "R4", "address order", 64'(mem_addr), 64'(addr_of(q[qh])));
            pay = 64'(mem_addr);
         end else begin
            chk(mem_data_valid === 1'b1 && mem_addr_valid === 1'b0, "R5", "data phase",
                64'({mem_addr_valid, mem_data_valid}), 64'd1);
            chk(mem_data === beat_of(q[qh], mb), "R5", "beat content", mem_data, beat_of(q[qh], mb));
            chk(mem_data_last === (mb == BEATS - 1), "R5", "last flag",
                64'(mem_data_last), 64'(mb == BEATS - 1));
            pay = mem_data;
         end
         if (prev_stall)
            chk(pay === prev_pay, "R6", "payload held", pay, prev_pay);
         prev_stall = (mcnt != 0) && (mph ? !dr : !ar);
         prev_pay   = pay;

         acc  = pv && pd && (mcnt < DEPTH);
         popd = mph && (mcnt > 0) && dr && (mb == BEATS - 1);
         if (!mph && mcnt > 0 && ar) begin
            mph = 1'b1; mb = 0;
         end else if (mph && dr) begin
            if (mb == BEATS - 1) begin mph = 1'b0; mb = 0; end
            else mb++;
         end
         if (acc) begin q[qt] = id; qt = (qt + 1) % 64; end
         if (popd) qh = (qh + 1) % 64;
         mcnt = mcnt + int'(acc) - int'(popd);
         if (acc && popd) coin++;
         if (pv && pd) id++;
         @(posedge clk);
         @(negedge clk);
      end
      chk(empty === 1'b1 && mcnt == 0, "R8", "drained at end", 64'(empty), 64'd1);
      chk(coin > 0, "R7", "push with completion seen", 64'(coin), 64'd1);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule